// File: doc/BRIEF.md
# Sticky Interrupt Status Unit with Zero-Write Clear

This block collects the completion and timeout events of a four-channel converter and turns them into a single interrupt request. Each channel raises a one-cycle pulse when a conversion finishes and another when a conversion overruns its time budget. The pulses set sticky flags in a 32-bit status word. A latch-enable word decides which events may set a flag. A separate route-enable word decides which set flags drive the interrupt line.

Software reaches the three words over a small word-addressed register port. The status word is not cleared by reading it. A write clears every flag whose bit is 0 in the written data, and it leaves every flag whose bit is 1 as it was. A handler therefore writes the inverse of the flags it has serviced. The register port uses valid/ready on both the request side and the read-response side. A read response is held until it is taken, and no new request is accepted while a response is waiting. Writes produce no response.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, all three words read 0, `irq_o` is 0 and `rsp_valid_o` is 0.
- R2: A pulse on `done_evt_i[c]` sets status bit 8+c, and a pulse on `tout_evt_i[c]` sets status bit 16+c. Each bit is set one cycle after the pulse, provided the same bit is set in the latch-enable word.
- R3: An event whose latch-enable bit is 0 leaves the status word unchanged.
- R4: Reading the status word does not change it. A set flag stays set until a write clears it.
- R5: A write to the status word at offset 0xE0 clears each flag whose data bit is 0. A data bit of 1 leaves its flag unchanged, and a write never sets a flag.
- R6: If an event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: `irq_o` is the OR of (status AND route-enable). It is registered, so it follows the status word one cycle later.
- R8: The route-enable word is at offset 0xC0 and the latch-enable word is at offset 0xD0. Only bits 11:8 and 19:16 of these words are writable. All other bits of all three words read 0.
- R9: A read of an address that is not aligned to 4, that lies above 0x130, or that holds no register returns 0. A misaligned write changes nothing.
- R10: A request is taken when `req_valid_i` and `req_ready_o` are both high. A read response stays valid with stable data until `rsp_ready_i` is high, and `req_ready_o` is low while a response is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_evt_i | input | NUM_CH | Per-channel conversion-finished pulses |
| tout_evt_i | input | NUM_CH | Per-channel conversion-timeout pulses |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response ready |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Several rules are checked by assertions on every cycle. A flag may rise only from an enabled event. A flag may fall only under a zero bit of a status write. An enabled event always leaves its flag set, even against a clear. The interrupt line tracks the masked status one cycle late. A held response stays stable and blocks new requests. Other behaviour can only be shown by the bench's scenarios: the exact read-back values, the unwritable and unmapped bits, misaligned accesses being ignored, and the latency of the interrupt at the ports.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_ROUTE   = 2'd1,
    SEL_LATCH   = 2'd2,
    SEL_STATUS  = 2'd3
  } reg_sel_e;

  // Mask with num_ch consecutive ones starting at bit lsb.
  function automatic word_t chan_mask(int num_ch, int lsb);
    word_t m;
    m = '0;
    for (int i = 0; i < num_ch; i++) m[lsb + i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/isu_reg_port.sv
module isu_reg_port
  import isu_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int OFF_ROUTE = 'hC0,
  parameter int OFF_LATCH = 'hD0,
  parameter int OFF_STAT  = 'hE0,
  parameter int MAP_END   = 'h130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  word_t             req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output word_t             rsp_rdata,
  input  word_t             route_q,
  input  word_t             latch_q,
  input  word_t             status_q,
  output logic              wr_route,
  output logic              wr_latch,
  output logic              wr_status,
  output word_t             wr_data
);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(OFF_ROUTE);
  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(OFF_LATCH);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(MAP_END);

  reg_sel_e sel;
  logic     accept;
  word_t    rd_word;

  always_comb begin
    sel = SEL_NONE;
    if (req_addr[1:0] == 2'b00 && req_addr <= A_END) begin
      if (req_addr == A_ROUTE)      sel = SEL_ROUTE;
      else if (req_addr == A_LATCH) sel = SEL_LATCH;
      else if (req_addr == A_STAT)  sel = SEL_STATUS;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ROUTE:  rd_word = route_q;
      SEL_LATCH:  rd_word = latch_q;
      SEL_STATUS: rd_word = status_q;
      default:    rd_word = '0;
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_route  = accept && req_write && sel == SEL_ROUTE;
  assign wr_latch  = accept && req_write && sel == SEL_LATCH;
  assign wr_status = accept && req_write && sel == SEL_STATUS;
  assign wr_data   = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/isu_enable_reg.sv
module isu_enable_reg
  import isu_pkg::*;
#(
  parameter word_t IMPL_MASK = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_stb,
  input  word_t wr_data,
  output word_t en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_stb) en_q <= wr_data & IMPL_MASK;
  end
endmodule

// File: rtl/isu_status_bank.sv
module isu_status_bank
  import isu_pkg::*;
#(
  parameter int    NUM_CH    = 4,
  parameter int    DONE_LSB  = 8,
  parameter int    TOUT_LSB  = 16,
  parameter word_t IMPL_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] done_evt,
  input  logic [NUM_CH-1:0] tout_evt,
  input  word_t             latch_en,
  input  logic              clr_stb,
  input  word_t             clr_data,
  output word_t             status_q
);
  word_t evt_word;
  word_t set_word;
  word_t keep_word;

  always_comb begin
    evt_word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      evt_word[DONE_LSB + c] = done_evt[c];
      evt_word[TOUT_LSB + c] = tout_evt[c];
    end
  end

  assign set_word  = evt_word & latch_en;
  // A zero data bit clears; a one keeps.
  assign keep_word = clr_stb ? clr_data : '1;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) status_q[b] <= 1'b0;
        else        status_q[b] <= set_word[b] | (status_q[b] & keep_word[b]);
      end
    end else begin : g_tie
      assign status_q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/isu_irq_gen.sv
module isu_irq_gen
  import isu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t status_q,
  input  word_t route_en,
  output logic  irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_q & route_en);
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isu_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 12,
  parameter int DONE_LSB  = 8,
  parameter int TOUT_LSB  = 16,
  parameter int OFF_ROUTE = 'hC0,
  parameter int OFF_LATCH = 'hD0,
  parameter int OFF_STAT  = 'hE0,
  parameter int MAP_END   = 'h130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] done_evt_i,
  input  logic [NUM_CH-1:0] tout_evt_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [31:0]       rsp_rdata_o,
  output logic              irq_o
);
  localparam word_t IMPL_MASK = chan_mask(NUM_CH, DONE_LSB) | chan_mask(NUM_CH, TOUT_LSB);

  word_t route_w, latch_w, status_w, wr_data_w;
  logic  wr_route_w, wr_latch_w, wr_status_w;
  logic  en_stb [2];
  word_t en_q   [2];

  isu_reg_port #(
    .ADDR_W(ADDR_W), .OFF_ROUTE(OFF_ROUTE), .OFF_LATCH(OFF_LATCH),
    .OFF_STAT(OFF_STAT), .MAP_END(MAP_END)
  ) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid_i), .req_ready(req_ready_o), .req_write(req_write_i),
    .req_addr(req_addr_i), .req_wdata(req_wdata_i),
    .rsp_valid(rsp_valid_o), .rsp_ready(rsp_ready_i), .rsp_rdata(rsp_rdata_o),
    .route_q(route_w), .latch_q(latch_w), .status_q(status_w),
    .wr_route(wr_route_w), .wr_latch(wr_latch_w), .wr_status(wr_status_w),
    .wr_data(wr_data_w)
  );

  assign en_stb[0] = wr_route_w;
  assign en_stb[1] = wr_latch_w;
  assign route_w   = en_q[0];
  assign latch_w   = en_q[1];

  for (genvar g = 0; g < 2; g++) begin : g_en
    isu_enable_reg #(.IMPL_MASK(IMPL_MASK)) u_en (
      .clk(clk), .rst_n(rst_n), .wr_stb(en_stb[g]), .wr_data(wr_data_w), .en_q(en_q[g])
    );
  end

  isu_status_bank #(
    .NUM_CH(NUM_CH), .DONE_LSB(DONE_LSB), .TOUT_LSB(TOUT_LSB), .IMPL_MASK(IMPL_MASK)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt_i), .tout_evt(tout_evt_i),
    .latch_en(latch_w), .clr_stb(wr_status_w), .clr_data(wr_data_w), .status_q(status_w)
  );

  isu_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .status_q(status_w), .route_en(route_w), .irq_q(irq_o)
  );
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import isu_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 12,
  parameter int DONE_LSB = 8,
  parameter int TOUT_LSB = 16,
  parameter int OFF_STAT = 'hE0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] done_evt_i,
  input logic [NUM_CH-1:0] tout_evt_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [31:0]       req_wdata_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [31:0]       rsp_rdata_o,
  input logic              irq_o,
  input word_t             status_q,
  input word_t             latch_q,
  input word_t             route_q
);
  localparam word_t LIVE = chan_mask(NUM_CH, DONE_LSB) | chan_mask(NUM_CH, TOUT_LSB);
  word_t set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      set_vec[DONE_LSB + c] = done_evt_i[c] & latch_q[DONE_LSB + c];
      set_vec[TOUT_LSB + c] = tout_evt_i[c] & latch_q[TOUT_LSB + c];
    end
  end

  assign clr_vec = (req_valid_i && req_ready_o && req_write_i &&
                    req_addr_i == ADDR_W'(OFF_STAT)) ? ~req_wdata_i : '0;

  // R2 R6
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R3
  no_spurious_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

  // R4 R5
  fall_only_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_q & $past(status_q) & ~$past(clr_vec)) == '0));

  // R7
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status_q & route_q))));

  // R8
  dead_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | latch_q | route_q) & ~LIVE) == '0);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o)));

  // R10
  stall_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o);
endmodule

bind irq_status_unit irq_status_unit_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DONE_LSB(DONE_LSB), .TOUT_LSB(TOUT_LSB), .OFF_STAT(OFF_STAT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .done_evt_i(done_evt_i), .tout_evt_i(tout_evt_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
  .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i), .rsp_rdata_o(rsp_rdata_o), .irq_o(irq_o),
  .status_q(status_w), .latch_q(latch_w), .route_q(route_w)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  localparam logic [11:0] A_ROUTE = 12'h0C0;
  localparam logic [11:0] A_LATCH = 12'h0D0;
  localparam logic [11:0] A_STAT  = 12'h0E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  done_evt = '0, tout_evt = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .done_evt_i(done_evt), .tout_evt_i(tout_evt),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_req(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_req(1'b0, a, '0);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] d, input logic [3:0] t);
    @(negedge clk); done_evt = d; tout_evt = t;
    @(negedge clk); done_evt = '0; tout_evt = '0;
  endtask

  // Monitor: pops expected read data as responses are taken.
  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected response", rsp_rdata, '0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, 0);
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", {31'd0, rsp_valid}, 0);
    bus_read(A_STAT,  32'h0, "R1 status reset");
    bus_read(A_LATCH, 32'h0, "R1 latch-enable reset");
    bus_read(A_ROUTE, 32'h0, "R1 route-enable reset");

    bus_req(1'b1, A_LATCH, 32'hFFFF_FFFF);
    bus_read(A_LATCH, 32'h000F_0F00, "R8 latch-enable writable bits");
    bus_req(1'b1, A_ROUTE, 32'h0000_0100);

    pulse(4'b0010, 4'b0000);
    @(negedge clk);
    chk(irq === 1'b0, "R7 unrouted flag keeps irq low", {31'd0, irq}, 0);
    bus_read(A_STAT, 32'h0000_0200, "R2 done B sets bit 9");

    pulse(4'b0001, 4'b0000);
    chk(irq === 1'b0, "R7 irq one cycle behind status", {31'd0, irq}, 0);
    @(negedge clk);
    chk(irq === 1'b1, "R7 irq rises for routed flag", {31'd0, irq}, 1);

    bus_read(A_STAT, 32'h0000_0300, "R4 status after first read");
    bus_read(A_STAT, 32'h0000_0300, "R4 status sticky on second read");

    bus_req(1'b1, A_STAT, 32'hFFFF_FEFF);
    bus_read(A_STAT, 32'h0000_0200, "R5 zero bit clears only bit 8");
    chk(irq === 1'b0, "R7 irq drops after clear", {31'd0, irq}, 0);
    bus_req(1'b1, A_STAT, 32'hFFFF_FFFF);
    bus_read(A_STAT, 32'h0000_0200, "R5 ones keep and never set");

    pulse(4'b0000, 4'b1000);
    bus_read(A_STAT, 32'h0008_0200, "R2 timeout D sets bit 19");

    bus_req(1'b1, A_LATCH, 32'h0000_0E00);
    pulse(4'b0001, 4'b0001);
    bus_read(A_STAT, 32'h0008_0200, "R3 disabled events not latched");

    bus_req(1'b1, A_LATCH, 32'h000F_0F00);
    @(negedge clk);
    done_evt = 4'b0010;
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_STAT; req_wdata = 32'h0;
    @(posedge clk); #1;
    done_evt = '0; req_valid = 1'b0;
    bus_read(A_STAT, 32'h0000_0200, "R6 event beats same-cycle clear");

    bus_read(12'h0E2, 32'h0, "R9 misaligned read");
    bus_read(12'h200, 32'h0, "R9 read beyond map");
    bus_read(12'h100, 32'h0, "R9 read of empty slot");
    bus_req(1'b1, 12'h0E1, 32'h0);
    bus_read(A_STAT, 32'h0000_0200, "R9 misaligned write ignored");

    @(negedge clk); rsp_ready = 1'b0;
    exp_q.push_back(32'h0000_0200); tag_q.push_back("R10 held response data");
    bus_req(1'b0, A_STAT, '0);
    @(negedge clk);
    begin
      automatic logic [31:0] held = rsp_rdata;
      chk(rsp_valid === 1'b1, "R10 response valid while stalled", {31'd0, rsp_valid}, 1);
      chk(req_ready === 1'b0, "R10 req_ready low while pending", {31'd0, req_ready}, 0);
      repeat (3) @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_rdata === held, "R10 response stable", rsp_rdata, held);
    end
    rsp_ready = 1'b1;
    repeat (2) @(negedge clk);

    bus_req(1'b1, A_ROUTE, 32'hFFFF_FFFF);
    bus_read(A_ROUTE, 32'h000F_0F00, "R8 route-enable writable bits");
    chk(irq === 1'b1, "R7 irq for newly routed flag", {31'd0, irq}, 1);

    bus_req(1'b1, A_STAT, 32'h0);
    bus_read(A_STAT, 32'h0, "R5 all-zero write clears all");
    chk(irq === 1'b0, "R7 irq low with no flags", {31'd0, irq}, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 0);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule